// File: doc/BRIEF.md
# Fetch Address Region Remapper

This block sits between an instruction fetch source and an instruction cache and rewrites fetch addresses through a small set of programmable windows. Each window is described by a descriptor: an enable, a size code, an alias base inside the low 512 MB code space, a target address, a downstream port choice and a burst style. Window sizes run from 2 MB to 128 MB in powers of two, and all addresses are held at 2 MB granularity.

For every presented fetch address the block decides without a clock edge whether an enabled window covers it. On a hit it swaps the address bits above the window offset for the target bits and reports which window won, which of two downstream ports should carry the access and whether the access should use incrementing or wrapping bursts. On a miss the address passes through unchanged. Descriptors are written and read back through a plain indexed configuration port.

Top module: `fetch_region_remapper`

## Requirements
- R1: After a synchronous active-low reset every descriptor reads back as zero and no fetch address produces a hit.
- R2: A configuration write with `cfg_we` high stores `cfg_wdata` into descriptor `cfg_idx` at the next rising edge. `cfg_rdata` shows descriptor `cfg_idx` without a clock edge. Cycles with `cfg_we` low change no descriptor. Descriptor word layout: bit 0 enable, bits 3:1 size code, bit 4 port select, bit 5 burst style (1 = incrementing), bits 13:6 base field (address bits 28:21), bits 24:14 target field (address bits 31:21).
- R3: A descriptor whose enable bit is 0, or whose size code is 0, never produces a hit.
- R4: Size code s (1 to 7) defines a window of 2^(20+s) bytes. An enabled descriptor hits when fetch address bits 31:29 are zero and bits 28:(20+s) equal the matching bits of the base field. Base bits below bit 20+s are ignored.
- R5: On a hit, output address bits 31:(20+s) come from the target field and bits (19+s):0 equal the fetch address. Target bits below bit 20+s are ignored.
- R6: When several descriptors hit, the lowest-numbered one sets `hit_region`, `out_addr`, `port_sel` and `burst_incr`.
- R7: When no descriptor hits, `hit` is 0, `hit_region` is 0, `out_addr` equals `fetch_addr`, `port_sel` is 0 (first port) and `burst_incr` is 0 (wrapping).
- R8: On a hit, `port_sel` and `burst_incr` equal the port select and burst style bits of the winning descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 2 | Descriptor index for writes and readback |
| cfg_wdata | input | 25 | Descriptor word to store |
| cfg_rdata | output | 25 | Descriptor word at `cfg_idx` |
| fetch_addr | input | 32 | Incoming fetch address |
| out_addr | output | 32 | Translated or passed-through address |
| hit | output | 1 | A descriptor covers `fetch_addr` |
| hit_region | output | 2 | Index of the winning descriptor |
| port_sel | output | 1 | Downstream port: 0 first, 1 second |
| burst_incr | output | 1 | Burst style: 0 wrapping, 1 incrementing |

## Verification
The hardest situation to reach is one where the compare boundary moves with the size code, so that a single address sits inside a window at one size and outside it at the next. The bench sweeps every size code across every descriptor slot with the same base and probes the first and last byte of the window, the bytes just outside it on each side, and an address above the code space. Priority is reached by programming a large low-numbered window over a small high-numbered one and then disabling the larger. A full sweep of all 256 alias blocks at the smallest size shows that exactly one block hits.

// File: rtl/frr_pkg.sv
// Package: shared widths and the descriptor layout for the fetch remapper.
// Assumes a 32-bit address space, a 512 MB code alias space and 2 MB granularity.
package frr_pkg;
    localparam int FRR_ADDR_W   = 32;
    localparam int FRR_ALIAS_W  = 29;
    localparam int FRR_GRAN_LSB = 21;
    localparam int FRR_SIZE_W   = 3;
    localparam int FRR_BASE_W   = FRR_ALIAS_W - FRR_GRAN_LSB;
    localparam int FRR_HI_W     = FRR_ADDR_W - FRR_GRAN_LSB;

    // Descriptor; the first member is the most significant, so enable sits at bit 0.
    typedef struct packed {
        logic [FRR_HI_W-1:0]   target;
        logic [FRR_BASE_W-1:0] base;
        logic                  burst_incr;
        logic                  port;
        logic [FRR_SIZE_W-1:0] size;
        logic                  en;
    } frr_desc_t;

    localparam int FRR_CFG_W = $bits(frr_desc_t);
endpackage

// File: rtl/frr_desc_bank.sv
// Module: descriptor storage. Holds NUM_REGIONS descriptors, writes them on
// the clock edge after a strobe and reads one back without a clock edge.
// Assumes the index is below NUM_REGIONS; other indices write nothing and read zero.
module frr_desc_bank
    import frr_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  idx,
    input  frr_desc_t                         wr_desc,
    output frr_desc_t                         rd_desc,
    output frr_desc_t [NUM_REGIONS-1:0]       desc_q
);
    logic idx_ok;

    // Purpose: flag an index that names an existing descriptor.
    always_comb begin
        idx_ok = (int'(idx) < NUM_REGIONS);
    end

    // Purpose: clear all descriptors on reset, store the addressed one on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else if (wr_en && idx_ok) begin
            desc_q[idx] <= wr_desc;
        end
    end

    // Purpose: present the addressed descriptor for readback.
    always_comb begin
        rd_desc = idx_ok ? desc_q[idx] : '0;
    end

    assert_write_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_ok) |=> (desc_q[$past(idx)] == $past(wr_desc)))
        else $error("descriptor write not committed");

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(desc_q))
        else $error("descriptor changed without a write");
endmodule

// File: rtl/frr_window.sv
// Module: one translation window. Decides whether the upper fetch address
// bits fall inside the window and forms the substituted upper bits.
// Assumes fetch_hi holds address bits ADDR_W-1 down to the granule LSB.
module frr_window
    import frr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win_en,
    input  logic [FRR_SIZE_W-1:0] win_size,
    input  logic [FRR_BASE_W-1:0] win_base,
    input  logic [FRR_HI_W-1:0]   win_target,
    input  logic [FRR_HI_W-1:0]   fetch_hi,
    output logic                  win_hit,
    output logic [FRR_HI_W-1:0]   xlat_hi
);
    logic [FRR_HI_W-1:0]   keep;
    logic [FRR_BASE_W-1:0] diff;
    logic                  alias_ok;

    // Purpose: mark the granule bits that lie above the window offset.
    always_comb begin
        for (int i = 0; i < FRR_HI_W; i++) begin
            keep[i] = ((i + 1) >= int'(win_size));
        end
    end

    // Purpose: compare the significant alias bits against the stored base.
    always_comb begin
        alias_ok = (fetch_hi[FRR_HI_W-1:FRR_BASE_W] == '0);
        diff     = (fetch_hi[FRR_BASE_W-1:0] ^ win_base) & keep[FRR_BASE_W-1:0];
        win_hit  = win_en && (win_size != '0) && alias_ok && (diff == '0);
    end

    // Purpose: take target bits above the offset, fetch bits below it.
    always_comb begin
        xlat_hi = (win_target & keep) | (fetch_hi & ~keep);
    end

    assert_size0_never_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_size == '0 || !win_en) |-> !win_hit)
        else $error("disabled window reported a hit");
endmodule

// File: rtl/frr_select.sv
// Module: priority selection. Picks the lowest-numbered hitting window and
// drives the output address, index, port and burst style from it.
// Assumes per-window translations are already formed.
module frr_select
    import frr_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_REGIONS-1:0]              win_hit,
    input  logic [NUM_REGIONS-1:0][FRR_HI_W-1:0] win_xlat,
    input  logic [NUM_REGIONS-1:0]              win_port,
    input  logic [NUM_REGIONS-1:0]              win_burst,
    input  logic [FRR_ADDR_W-1:0]               fetch_addr,
    output logic                                sel_hit,
    output logic [IDX_W-1:0]                    sel_idx,
    output logic [FRR_ADDR_W-1:0]               sel_addr,
    output logic                                sel_port,
    output logic                                sel_burst
);
    // Purpose: scan from the top down so the lowest hitting index wins.
    always_comb begin
        sel_hit = 1'b0;
        sel_idx = '0;
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (win_hit[r]) begin
                sel_hit = 1'b1;
                sel_idx = IDX_W'(r);
            end
        end
    end

    // Purpose: route the winner's translation and attributes, or pass through.
    always_comb begin
        if (sel_hit) begin
            sel_addr  = {win_xlat[sel_idx], fetch_addr[FRR_GRAN_LSB-1:0]};
            sel_port  = win_port[sel_idx];
            sel_burst = win_burst[sel_idx];
        end else begin
            sel_addr  = fetch_addr;
            sel_port  = 1'b0;
            sel_burst = 1'b0;
        end
    end

    assert_hit_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit == (win_hit != '0))
        else $error("hit flag disagrees with window hits");

    assert_winner_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |-> win_hit[sel_idx])
        else $error("winner does not hit");

    assert_no_lower_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |-> ((win_hit & ((NUM_REGIONS'(1) << sel_idx) - NUM_REGIONS'(1))) == '0))
        else $error("a lower-numbered window also hits");
endmodule

// File: rtl/fetch_region_remapper.sv
// Module: top of the fetch address remapper. Stores the descriptors, runs one
// window per descriptor in parallel and selects the winner.
// Assumes translation is consumed in the same cycle it is presented.
module fetch_region_remapper
    import frr_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [FRR_CFG_W-1:0]  cfg_wdata,
    output logic [FRR_CFG_W-1:0]  cfg_rdata,
    input  logic [FRR_ADDR_W-1:0] fetch_addr,
    output logic [FRR_ADDR_W-1:0] out_addr,
    output logic                  hit,
    output logic [IDX_W-1:0]      hit_region,
    output logic                  port_sel,
    output logic                  burst_incr
);
    frr_desc_t [NUM_REGIONS-1:0]         desc_q;
    frr_desc_t                           rd_desc;
    logic [NUM_REGIONS-1:0]              win_hit;
    logic [NUM_REGIONS-1:0][FRR_HI_W-1:0] win_xlat;
    logic [NUM_REGIONS-1:0]              win_port;
    logic [NUM_REGIONS-1:0]              win_burst;

    frr_desc_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .idx     (cfg_idx),
        .wr_desc (frr_desc_t'(cfg_wdata)),
        .rd_desc (rd_desc),
        .desc_q  (desc_q)
    );

    // Purpose: expose the addressed descriptor as a flat word.
    always_comb begin
        cfg_rdata = FRR_CFG_W'(rd_desc);
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
        frr_window u_win (
            .clk        (clk),
            .rst_n      (rst_n),
            .win_en     (desc_q[r].en),
            .win_size   (desc_q[r].size),
            .win_base   (desc_q[r].base),
            .win_target (desc_q[r].target),
            .fetch_hi   (fetch_addr[FRR_ADDR_W-1:FRR_GRAN_LSB]),
            .win_hit    (win_hit[r]),
            .xlat_hi    (win_xlat[r])
        );

        // Purpose: gather this window's routing attributes.
        always_comb begin
            win_port[r]  = desc_q[r].port;
            win_burst[r] = desc_q[r].burst_incr;
        end
    end

    frr_select #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_hit    (win_hit),
        .win_xlat   (win_xlat),
        .win_port   (win_port),
        .win_burst  (win_burst),
        .fetch_addr (fetch_addr),
        .sel_hit    (hit),
        .sel_idx    (hit_region),
        .sel_addr   (out_addr),
        .sel_port   (port_sel),
        .sel_burst  (burst_incr)
    );

    assert_miss_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (out_addr == fetch_addr && !port_sel && !burst_incr && hit_region == '0))
        else $error("miss did not pass through");

    assert_low_bits_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr[FRR_GRAN_LSB-1:0] == fetch_addr[FRR_GRAN_LSB-1:0])
        else $error("sub-granule offset altered");

    assert_hit_in_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (fetch_addr[FRR_ADDR_W-1:FRR_ALIAS_W] == '0))
        else $error("hit outside code alias space");
endmodule

// File: tb/fetch_region_remapper_bench.sv
module fetch_region_remapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [24:0] cfg_wdata = '0;
    logic [24:0] cfg_rdata;
    logic [31:0] fetch_addr = '0;
    logic [31:0] out_addr;
    logic        hit;
    logic [1:0]  hit_region;
    logic        port_sel;
    logic        burst_incr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench-side copy of what has been programmed
    logic        m_en [4];
    logic [2:0]  m_size [4];
    logic        m_port [4];
    logic        m_burst [4];
    logic [7:0]  m_base [4];
    logic [10:0] m_target [4];

    logic        e_hit;
    logic [1:0]  e_idx;
    logic [31:0] e_addr;
    logic        e_port;
    logic        e_burst;

    always #10 clk = ~clk;

    fetch_region_remapper u_fetch_region_remapper (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fetch_addr(fetch_addr),
        .out_addr(out_addr), .hit(hit), .hit_region(hit_region),
        .port_sel(port_sel), .burst_incr(burst_incr)
    );

    function automatic logic [24:0] pack(input logic en, input logic [2:0] sz,
                                         input logic pt, input logic bi,
                                         input logic [7:0] b, input logic [10:0] t);
        return {t, b, bi, pt, sz, en};
    endfunction

    task automatic model(input logic [31:0] a);
        e_hit = 0; e_idx = 0; e_addr = a; e_port = 0; e_burst = 0;
        for (int r = 0; r < 4; r++) begin
            if (!e_hit && m_en[r] && m_size[r] != 0 && a[31:29] == 3'b000) begin
                int sh = 20 + int'(m_size[r]);
                longint unsigned base_a = longint'(m_base[r]) << 21;
                longint unsigned tgt_a  = longint'(m_target[r]) << 21;
                longint unsigned aa     = longint'(a);
                if ((aa >> sh) == (base_a >> sh)) begin
                    e_hit = 1; e_idx = 2'(r);
                    e_addr = 32'(((tgt_a >> sh) << sh) | (aa & ((64'd1 << sh) - 1)));
                    e_port = m_port[r]; e_burst = m_burst[r];
                end
            end
        end
    endtask

    task automatic write_desc(input int r, input logic en, input logic [2:0] sz,
                              input logic pt, input logic bi,
                              input logic [7:0] b, input logic [10:0] t);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2'(r); cfg_wdata = pack(en, sz, pt, bi, b, t);
        @(negedge clk);
        cfg_we = 0;
        m_en[r] = en; m_size[r] = sz; m_port[r] = pt; m_burst[r] = bi;
        m_base[r] = b; m_target[r] = t;
    endtask

    task automatic probe(input logic [31:0] a, input string req);
        model(a);
        @(negedge clk);
        fetch_addr = a;
        #2;
        checks++;
        if (hit !== e_hit || hit_region !== e_idx || out_addr !== e_addr ||
            port_sel !== e_port || burst_incr !== e_burst) begin
            failures++;
            $display("FAIL %s addr=%h actual hit=%0b idx=%0d out=%h port=%0b burst=%0b expected hit=%0b idx=%0d out=%h port=%0b burst=%0b",
                     req, a, hit, hit_region, out_addr, port_sel, burst_incr,
                     e_hit, e_idx, e_addr, e_port, e_burst);
        end
    endtask

    task automatic readback(input int r, input string req);
        logic [24:0] exp;
        exp = pack(m_en[r], m_size[r], m_port[r], m_burst[r], m_base[r], m_target[r]);
        @(negedge clk);
        cfg_idx = 2'(r);
        #2;
        checks++;
        if (cfg_rdata !== exp) begin
            failures++;
            $display("FAIL %s readback idx=%0d actual=%h expected=%h", req, r, cfg_rdata, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            m_en[r] = 0; m_size[r] = 0; m_port[r] = 0; m_burst[r] = 0;
            m_base[r] = 0; m_target[r] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state, all descriptors zero, nothing hits
        for (int r = 0; r < 4; r++) readback(r, "R1");
        probe(32'h0000_0000, "R1");
        probe(32'h1234_5678, "R1");
        probe(32'hF000_0004, "R7");

        // R2: write one descriptor, others untouched, strobe-low cycle ignored
        write_desc(2, 1, 3'd2, 1, 0, 8'h3C, 11'h2A5);
        for (int r = 0; r < 4; r++) readback(r, "R2");
        @(negedge clk);
        cfg_idx = 2'd2; cfg_wdata = 25'h1FF_FFFF;
        repeat (2) @(negedge clk);
        readback(2, "R2");
        write_desc(2, 0, 0, 0, 0, 0, 0);

        // R4 R5 R8: every size in every slot, probes at and around the edges
        for (int s = 1; s <= 7; s++) begin
            for (int r = 0; r < 4; r++) begin
                logic [31:0] sz;
                logic [31:0] start;
                sz = 32'd1 << (20 + s);
                start = (32'(8'hA5) << 21) & ~(sz - 1);
                write_desc(r, 1, 3'(s), r[0], ~r[0], 8'hA5, 11'h5C3 ^ 11'(r));
                probe(start, "R4");
                probe(start + sz - 1, "R5");
                probe(start + sz, "R4");
                probe(start - 1, "R4");
                probe(start | 32'h2000_0000, "R4");
                probe(start + (sz >> 1) + 32'd7, "R8");
                write_desc(r, 0, 0, 0, 0, 0, 0);
            end
        end

        // R4: smallest window, every alias block, exactly one hits
        write_desc(0, 1, 3'd1, 0, 1, 8'h10, 11'h7FF);
        for (int b = 0; b < 256; b++) probe((32'(b) << 21) | 32'h0001_2345, "R4");

        // R3: size zero and enable zero never hit
        write_desc(0, 1, 3'd0, 1, 1, 8'h10, 11'h7FF);
        probe(32'h0200_0000, "R3");
        write_desc(0, 0, 3'd3, 1, 1, 8'h10, 11'h7FF);
        probe(32'h0200_0000, "R3");

        // R6: large low-numbered window over a small high-numbered one
        write_desc(3, 1, 3'd1, 0, 0, 8'h40, 11'h111);
        write_desc(0, 1, 3'd7, 1, 1, 8'h40, 11'h7C0);
        probe(32'h0800_1000, "R6");
        write_desc(0, 0, 3'd7, 1, 1, 8'h40, 11'h7C0);
        probe(32'h0800_1000, "R6");
        write_desc(1, 1, 3'd4, 1, 0, 8'h44, 11'h0AB);
        write_desc(2, 1, 3'd2, 0, 1, 8'h44, 11'h3CD);
        probe(32'h0880_0010, "R6");
        probe(32'h0890_0010, "R6");
        probe(32'h1000_0000, "R7");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule